// File: doc/BRIEF.md
# Serial Programming Host Sequencer

This block is the host side of a two-wire serial programming link to a small microcontroller target. It owns four target-facing lines: a serial clock, a bidirectional data line (output value plus output enable), a mode-select line and the target reset line. A level request `prog_en` brings the target into low-voltage program mode and takes it back out. Each step of the entry and exit order is separated by a delay counted in system clocks.

While the link is up, command frames arrive on a valid/ready request port. Each frame holds a 4-bit command code and a 16-bit operand. The block shifts the frame out least significant bit first, and the command nibble goes before the operand. For read-type codes it releases the data line for the upper operand byte and gathers the byte the target returns. That byte is offered on a valid/ready response port.

Back-pressure works as follows. `req_ready` is high only when all of these hold: the link is up, no frame is in flight, the single response slot is empty and `prog_en` is high. A request transfers on a cycle where `req_valid` and `req_ready` are both high. The response slot keeps `rsp_valid` and `rsp_data` unchanged until `rsp_ready` is seen high. Until then, no new request is taken.

Top module: `pgm_host_seq`

## Requirements
- R1: With the link down, raising `prog_en` drives `tgt_mode` high at the next clock edge. `tgt_rst` goes high `SETUP_CYC` clocks after that, and `linked` goes high `HOLD_CYC` clocks after `tgt_rst`. Throughout this order, `tgt_clk` and `tgt_dat_o` stay low and `tgt_dat_oe` stays high.
- R2: With the link up and no frame in flight, lowering `prog_en` makes `tgt_rst` and `linked` fall at the next clock edge. At that point `tgt_dat_o` is forced low and `tgt_clk` is low. `tgt_mode` falls `HOLD_CYC` clocks later.
- R3: A frame makes exactly 20 rising edges on `tgt_clk`. The data bit present during high phase k is bit k of the 20-bit word {operand, command}. This means bits 0..3 carry command bits 0..3, and bits 4..19 carry operand bits 0..15.
- R4: The first rising edge of a frame comes after a low lead-in phase. Every high phase lasts `HALF_CYC` clocks, and every low phase between two rising edges also lasts `HALF_CYC` clocks. `tgt_dat_o` changes during a frame only on a clock where `tgt_clk` rises.
- R5: Command codes 4'b1000, 4'b1001, 4'b1010, 4'b1011 and 4'b0010 are read-type and return one byte. All other codes are write-type: they drive all 16 operand bits and produce no response.
- R6: In a read-type frame, `tgt_dat_oe` is low during high phases 12..19 (operand bits 8..15) and high during phases 0..11. In a write-type frame it stays high. It is high again no later than the final falling edge, and it is always high when no frame is in flight.
- R7: In a read-type frame, `tgt_dat_i` is sampled on the last system clock of each of high phases 12..19. The bit from phase 12 lands in `rsp_data[0]` and the bit from phase 19 lands in `rsp_data[7]`.
- R8: `rsp_valid` rises on the same edge as the final falling clock edge of a read-type frame. It then holds, with `rsp_data` stable, until a cycle with `rsp_ready` high.
- R9: A request transfers only when `linked` is high, no frame is in flight, no response is pending and `prog_en` is high. Requests made while the link is down are ignored and cause no activity on `tgt_clk`.
- R10: `busy` rises on the edge after a request transfers and stays high for exactly 40*`HALF_CYC` clocks. It falls on the same edge as the final falling edge of `tgt_clk`, and `tgt_clk` is never high while `busy` is low.
- R11: Lowering `prog_en` during a frame does not cut the frame short. `tgt_rst` and `linked` stay high until `busy` falls, and the exit order of R2 starts on the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_en | input | 1 | Level request to hold the target in program mode |
| linked | output | 1 | Entry order complete, frames may be sent |
| busy | output | 1 | A frame is being shifted |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_cmd | input | 4 | Command code of the request |
| req_opnd | input | 16 | Operand of the request |
| rsp_valid | output | 1 | Returned byte available |
| rsp_ready | input | 1 | Consumer takes the returned byte |
| rsp_data | output | 8 | Byte returned by the target |
| tgt_clk | output | 1 | Serial clock to the target |
| tgt_dat_o | output | 1 | Data value driven toward the target |
| tgt_dat_oe | output | 1 | Data line drive enable (1 = host drives) |
| tgt_dat_i | input | 1 | Data line value as seen from the target side |
| tgt_mode | output | 1 | Low-voltage programming mode select |
| tgt_rst | output | 1 | Target reset line, high releases the target into program mode |

## Verification
All sixteen command codes are sent once. This separates the five read-type codes from the write-type ones, both by the enable pattern on the data line and by whether a response appears. All-ones and all-zeros operands, mixed with random operands and random returned bytes, expose reversed bit order, a swapped nibble and operand order, and capture bits landing in the wrong position. Response stalls of several lengths test the hold and back-pressure rules. Two further patterns show that the link order on the mode and reset lines is honoured rather than cut short: a shutdown request raised in the middle of a frame, and requests offered while the link is down.

// File: rtl/pgm_host_pkg.sv
package pgm_host_pkg;

  localparam int unsigned CMD_W    = 4;
  localparam int unsigned OPND_W   = 16;
  localparam int unsigned FRAME_W  = CMD_W + OPND_W;
  localparam int unsigned RX_W     = 8;
  localparam int unsigned TURN_BIT = FRAME_W - RX_W;
  localparam int unsigned BIT_W    = $clog2(FRAME_W);

  typedef enum logic [2:0] {
    LK_OFF,
    LK_RAISE_MODE,
    LK_SETTLE,
    LK_ON,
    LK_DROP_RST
  } link_st_t;

  typedef enum logic [1:0] {
    SH_IDLE,
    SH_LEAD,
    SH_HIGH,
    SH_LOW
  } shift_st_t;

  // Read-type codes hand back one byte in the upper operand half.
  function automatic logic cmd_returns_byte(input logic [CMD_W-1:0] code);
    return (code[3:2] == 2'b10) || (code == 4'b0010);
  endfunction

endpackage

// File: rtl/pgm_delay_cnt.sv
module pgm_delay_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  // Counts 0..limit, wraps by itself so back-to-back phases need no clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || last) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last = (cnt_q == limit);

endmodule

// File: rtl/pgm_link_seq.sv
module pgm_link_seq
  import pgm_host_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 8,
  parameter int unsigned HOLD_CYC  = 6,
  parameter int unsigned CNT_W     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_on,
  input  logic frame_busy,
  output logic mode_o,
  output logic rst_line_o,
  output logic linked_o,
  output logic zero_dat_o
);

  link_st_t         st_q, st_d;
  logic             mode_q, rstl_q;
  logic             tmr_clr, tmr_last;
  logic [CNT_W-1:0] tmr_lim;

  assign tmr_clr = (st_q == LK_OFF) || (st_q == LK_ON);
  assign tmr_lim = (st_q == LK_RAISE_MODE) ? CNT_W'(SETUP_CYC - 1)
                                           : CNT_W'(HOLD_CYC - 1);

  pgm_delay_cnt #(.CNT_W(CNT_W)) u_step_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .limit (tmr_lim),
    .last  (tmr_last)
  );

  always_comb begin
    st_d       = st_q;
    zero_dat_o = 1'b0;
    unique case (st_q)
      LK_OFF:        if (want_on) st_d = LK_RAISE_MODE;
      LK_RAISE_MODE: if (tmr_last) st_d = LK_SETTLE;
      LK_SETTLE:     if (tmr_last) st_d = LK_ON;
      LK_ON: begin
        // Exit waits for any frame in flight to finish.
        if (!want_on && !frame_busy) begin
          st_d       = LK_DROP_RST;
          zero_dat_o = 1'b1;
        end
      end
      LK_DROP_RST:   if (tmr_last) st_d = LK_OFF;
      default:       st_d = LK_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LK_OFF;
      mode_q <= 1'b0;
      rstl_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= (st_d != LK_OFF);
      rstl_q <= (st_d == LK_SETTLE) || (st_d == LK_ON);
    end
  end

  assign mode_o     = mode_q;
  assign rst_line_o = rstl_q;
  assign linked_o   = (st_q == LK_ON);

endmodule

// File: rtl/pgm_frame_shift.sv
module pgm_frame_shift
  import pgm_host_pkg::*;
#(
  parameter int unsigned HALF_CYC = 4,
  parameter int unsigned CNT_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [OPND_W-1:0] opnd,
  input  logic              zero_dat,
  input  logic              sdi,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              byte_vld_o,
  output logic [RX_W-1:0]   byte_nxt_o
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);
  localparam logic [BIT_W-1:0] TURN_IDX = BIT_W'(TURN_BIT);

  shift_st_t          st_q;
  logic [FRAME_W-1:0] sr_q;
  logic [BIT_W-1:0]   bit_q, bit_nxt;
  logic               rd_q, in_rx;
  logic [RX_W-1:0]    rx_q;
  logic               sclk_q, sdo_q, oe_q;
  logic               tmr_last;

  pgm_delay_cnt #(.CNT_W(CNT_W)) u_half_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st_q == SH_IDLE),
    .limit (CNT_W'(HALF_CYC - 1)),
    .last  (tmr_last)
  );

  assign bit_nxt    = bit_q + 1'b1;
  assign in_rx      = rd_q && (bit_q >= TURN_IDX);
  assign byte_nxt_o = {sdi, rx_q[RX_W-1:1]};
  assign byte_vld_o = (st_q == SH_HIGH) && tmr_last && (bit_q == LAST_BIT) && rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      sr_q   <= '0;
      bit_q  <= '0;
      rd_q   <= 1'b0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      sdo_q  <= 1'b0;
      oe_q   <= 1'b1;
    end else begin
      unique case (st_q)
        SH_IDLE: begin
          if (zero_dat) sdo_q <= 1'b0;
          if (start) begin
            st_q  <= SH_LEAD;
            sr_q  <= {opnd, cmd};
            bit_q <= '0;
            rd_q  <= cmd_returns_byte(cmd);
          end
        end
        SH_LEAD: begin
          if (tmr_last) begin
            st_q   <= SH_HIGH;
            sclk_q <= 1'b1;
            sdo_q  <= sr_q[0];
          end
        end
        SH_HIGH: begin
          if (tmr_last) begin
            sclk_q <= 1'b0;
            if (in_rx) rx_q <= byte_nxt_o;
            if (bit_q == LAST_BIT) begin
              st_q <= SH_IDLE;
              oe_q <= 1'b1;
            end else begin
              st_q <= SH_LOW;
            end
          end
        end
        SH_LOW: begin
          if (tmr_last) begin
            st_q   <= SH_HIGH;
            sclk_q <= 1'b1;
            sr_q   <= sr_q >> 1;
            sdo_q  <= sr_q[1];
            bit_q  <= bit_nxt;
            oe_q   <= !(rd_q && (bit_nxt >= TURN_IDX));
          end
        end
        default: st_q <= SH_IDLE;
      endcase
    end
  end

  assign busy_o   = (st_q != SH_IDLE);
  assign sclk_o   = sclk_q;
  assign sdo_o    = sdo_q;
  assign sdo_oe_o = oe_q;

endmodule

// File: rtl/pgm_host_seq.sv
module pgm_host_seq
  import pgm_host_pkg::*;
#(
  parameter int unsigned HALF_CYC  = 4,
  parameter int unsigned SETUP_CYC = 8,
  parameter int unsigned HOLD_CYC  = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prog_en,
  output logic        linked,
  output logic        busy,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [3:0]  req_cmd,
  input  logic [15:0] req_opnd,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [7:0]  rsp_data,
  output logic        tgt_clk,
  output logic        tgt_dat_o,
  output logic        tgt_dat_oe,
  input  logic        tgt_dat_i,
  output logic        tgt_mode,
  output logic        tgt_rst
);

  localparam int unsigned LINK_MAX = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int unsigned LINK_W   = $clog2(LINK_MAX + 1);
  localparam int unsigned HALF_W   = $clog2(HALF_CYC + 1);

  logic            accept, frame_busy, zero_dat, byte_vld;
  logic [RX_W-1:0] byte_nxt;
  logic            rsp_vld_q;
  logic [RX_W-1:0] rsp_dat_q;

  pgm_link_seq #(
    .SETUP_CYC (SETUP_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .CNT_W     (LINK_W)
  ) u_link (
    .clk        (clk),
    .rst_n      (rst_n),
    .want_on    (prog_en),
    .frame_busy (frame_busy),
    .mode_o     (tgt_mode),
    .rst_line_o (tgt_rst),
    .linked_o   (linked),
    .zero_dat_o (zero_dat)
  );

  assign req_ready = linked && !frame_busy && !rsp_vld_q && prog_en;
  assign accept    = req_valid && req_ready;

  pgm_frame_shift #(
    .HALF_CYC (HALF_CYC),
    .CNT_W    (HALF_W)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .cmd        (req_cmd),
    .opnd       (req_opnd),
    .zero_dat   (zero_dat),
    .sdi        (tgt_dat_i),
    .busy_o     (frame_busy),
    .sclk_o     (tgt_clk),
    .sdo_o      (tgt_dat_o),
    .sdo_oe_o   (tgt_dat_oe),
    .byte_vld_o (byte_vld),
    .byte_nxt_o (byte_nxt)
  );

  // Single response slot; loaded on the final falling edge so it is full
  // before req_ready could rise again.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld_q <= 1'b0;
      rsp_dat_q <= '0;
    end else if (byte_vld) begin
      rsp_vld_q <= 1'b1;
      rsp_dat_q <= byte_nxt;
    end else if (rsp_ready) begin
      rsp_vld_q <= 1'b0;
    end
  end

  assign busy      = frame_busy;
  assign rsp_valid = rsp_vld_q;
  assign rsp_data  = rsp_dat_q;

endmodule

// File: rtl/pgm_host_seq_chk.sv
module pgm_host_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       linked,
  input logic       busy,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       tgt_clk,
  input logic       tgt_dat_o,
  input logic       tgt_dat_oe,
  input logic       tgt_mode,
  input logic       tgt_rst
);

  AST_ENTRY_LINES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_rst) |-> tgt_mode && !tgt_clk && !tgt_dat_o && tgt_dat_oe); // R1

  AST_EXIT_LINES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_rst) |-> tgt_mode && !tgt_clk && !tgt_dat_o && tgt_dat_oe && !linked); // R2

  AST_MODE_DROPS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_mode) |-> !tgt_rst); // R2

  AST_DATA_MOVES_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !$rose(tgt_clk) |-> $stable(tgt_dat_o)); // R4

  AST_OE_HIGH_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tgt_dat_oe); // R6

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R8

  AST_ACCEPT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |-> linked && !busy && !rsp_valid); // R9

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy); // R10

  AST_CLK_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_clk |-> busy); // R10

  AST_LINK_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> tgt_rst && tgt_mode); // R11

endmodule

bind pgm_host_seq pgm_host_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .linked     (linked),
  .busy       (busy),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data),
  .tgt_clk    (tgt_clk),
  .tgt_dat_o  (tgt_dat_o),
  .tgt_dat_oe (tgt_dat_oe),
  .tgt_mode   (tgt_mode),
  .tgt_rst    (tgt_rst)
);

// File: tb/pgm_host_seq_tb_top.sv
module pgm_host_seq_tb_top;

  localparam int HALF  = 3;
  localparam int SETUP = 5;
  localparam int HOLD  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_en = 1'b0;
  logic        linked, busy;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_cmd = '0;
  logic [15:0] req_opnd = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [7:0]  rsp_data;
  logic        tgt_clk, tgt_dat_o, tgt_dat_oe;
  logic        tgt_dat_i = 1'b0;
  logic        tgt_mode, tgt_rst;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // target model state
  int         fidx = 0;
  int         bad_phase = 0;
  logic [7:0] tgt_byte = '0;
  logic [19:0] rec_bit, rec_oe;

  always #5 clk = ~clk;

  pgm_host_seq #(
    .HALF_CYC  (HALF),
    .SETUP_CYC (SETUP),
    .HOLD_CYC  (HOLD)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .linked(linked), .busy(busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd), .req_opnd(req_opnd),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .tgt_clk(tgt_clk), .tgt_dat_o(tgt_dat_o), .tgt_dat_oe(tgt_dat_oe),
    .tgt_dat_i(tgt_dat_i), .tgt_mode(tgt_mode), .tgt_rst(tgt_rst)
  );

  function automatic logic is_read(input logic [3:0] c);
    return (c == 4'b1000) || (c == 4'b1001) || (c == 4'b1010) ||
           (c == 4'b1011) || (c == 4'b0010);
  endfunction

  function automatic logic [19:0] exp_bits(input logic [3:0] c, input logic [15:0] op);
    return {op, c};
  endfunction

  function automatic logic [19:0] exp_oe(input logic [3:0] c);
    logic [19:0] v;
    for (int k = 0; k < 20; k++) v[k] = !(is_read(c) && k >= 12);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Target model: observes the serial clock at system negedges.
  initial begin
    logic prev_c;
    int   run;
    prev_c = 1'b0;
    run = 0;
    forever begin
      @(negedge clk);
      if (tgt_clk !== prev_c) begin
        if (prev_c && run != HALF) bad_phase++;
        if (!prev_c && fidx > 0 && run != HALF) bad_phase++;
        if (tgt_clk) begin
          if (fidx < 20) begin
            rec_bit[fidx] = tgt_dat_o;
            rec_oe[fidx]  = tgt_dat_oe;
          end
          if (fidx >= 12 && fidx < 20) tgt_dat_i = tgt_byte[fidx-12];
          else tgt_dat_i = 1'($urandom);
          fidx++;
        end
        run = 1;
      end else begin
        run++;
      end
      prev_c = tgt_clk;
    end
  end

  task automatic enter_mode();
    int n;
    prog_en = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!tgt_mode && n < 100);
    chk(n == 1, "R1 mode-select rise delay", n, 1);
    chk(!tgt_rst && !tgt_clk && !tgt_dat_o && tgt_dat_oe, "R1 lines at mode rise",
        {tgt_rst, tgt_clk, tgt_dat_o, tgt_dat_oe}, 4'b0001);
    n = 0;
    do begin
      @(negedge clk); n++;
      if (tgt_clk || tgt_dat_o || !tgt_dat_oe) chk(0, "R1 lines quiet during entry", n, 0);
    end while (!tgt_rst && n < 100);
    chk(n == SETUP, "R1 reset rise delay", n, SETUP);
    chk(tgt_mode, "R1 mode still high at reset rise", tgt_mode, 1);
    n = 0;
    do begin @(negedge clk); n++; end while (!linked && n < 100);
    chk(n == HOLD, "R1 linked delay", n, HOLD);
  endtask

  task automatic leave_mode();
    int n;
    prog_en = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (tgt_rst && n < 100);
    chk(n == 1, "R2 reset drop delay", n, 1);
    chk(tgt_mode && !tgt_clk && !tgt_dat_o && tgt_dat_oe && !linked, "R2 lines at reset drop",
        {tgt_mode, tgt_clk, tgt_dat_o, tgt_dat_oe, linked}, 5'b10010);
    n = 0;
    do begin @(negedge clk); n++; end while (tgt_mode && n < 100);
    chk(n == HOLD, "R2 mode-select drop delay", n, HOLD);
  endtask

  task automatic run_frame(input logic [3:0] c, input logic [15:0] op,
                           input logic [7:0] tb, input int stall, input bit drop_mid);
    int nb, rdy_busy, link_lost;
    logic [7:0] held;
    tgt_byte = tb;
    fidx = 0;
    bad_phase = 0;
    @(negedge clk);
    req_cmd = c; req_opnd = op; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    nb = 0; rdy_busy = 0; link_lost = 0;
    while (busy) begin
      nb++;
      if (req_ready) rdy_busy++;
      if (drop_mid && nb == 8) prog_en = 1'b0;
      if (drop_mid && nb > 8 && (!tgt_rst || !linked)) link_lost++;
      @(negedge clk);
    end
    chk(nb == 40 * HALF, "R10 busy length", nb, 40 * HALF);
    chk(rdy_busy == 0, "R9 no ready while busy", rdy_busy, 0);
    if (drop_mid) chk(link_lost == 0 && tgt_rst, "R11 exit deferred to frame end", link_lost, 0);
    chk(fidx == 20, "R3 rising edge count", fidx, 20);
    chk(rec_bit == exp_bits(c, op), "R3 frame bits", rec_bit, exp_bits(c, op));
    chk(bad_phase == 0, "R4 phase lengths", bad_phase, 0);
    chk(rec_oe == exp_oe(c), "R6 enable pattern", rec_oe, exp_oe(c));
    chk(tgt_dat_oe && !tgt_clk, "R6 enable back at frame end", {tgt_dat_oe, tgt_clk}, 2'b10);
    chk(rsp_valid == is_read(c), "R5 response presence by code", rsp_valid, is_read(c));
    if (is_read(c)) begin
      chk(rsp_data == tb, "R7 returned byte", rsp_data, tb);
      held = rsp_data;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(rsp_valid && rsp_data == held && !req_ready, "R8 response held under stall",
            {rsp_valid, rsp_data, req_ready}, {1'b1, held, 1'b0});
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(!rsp_valid, "R8 response released", rsp_valid, 0);
    end
  endtask

  initial begin
    int rises, rdy, tmp;
    logic [3:0] c;
    tmp = $urandom(32'h5EED);
    repeat (4) @(negedge clk);
    chk(!tgt_mode && !tgt_rst && !tgt_clk && !tgt_dat_o && tgt_dat_oe && !linked &&
        !busy && !rsp_valid && !req_ready, "R1 reset state",
        {tgt_mode, tgt_rst, tgt_clk, tgt_dat_o, tgt_dat_oe, linked, busy, rsp_valid, req_ready},
        9'b000010000);
    rst_n = 1'b1;
    @(negedge clk);

    // requests while link down
    req_valid = 1'b1; req_cmd = 4'b1000; rises = 0; rdy = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tgt_clk || busy) rises++;
      if (req_ready) rdy++;
    end
    req_valid = 1'b0;
    chk(rises == 0 && rdy == 0, "R9 requests ignored while link down", rises + rdy, 0);

    enter_mode();

    for (int k = 0; k < 16; k++)
      run_frame(4'(k), 16'($urandom), 8'($urandom), k % 4, 1'b0);
    run_frame(4'b1001, 16'hFFFF, 8'h00, 2, 1'b0);
    run_frame(4'b1101, 16'h0000, 8'hFF, 0, 1'b0);
    run_frame(4'b0000, 16'hFFFF, 8'h5A, 0, 1'b0);
    run_frame(4'b0010, 16'h00A5, 8'hFF, 5, 1'b0);
    run_frame(4'b1011, 16'h8001, 8'h81, 1, 1'b0);

    for (int i = 0; i < 30; i++) begin
      c = ($urandom % 2) ? 4'(4'b1000 + ($urandom % 4)) : 4'($urandom);
      run_frame(c, 16'($urandom), 8'($urandom), $urandom % 4, 1'b0);
    end

    run_frame(4'b1100, 16'hC3E1, 8'h00, 0, 1'b1);
    leave_mode();

    enter_mode();
    run_frame(4'b1010, 16'h1234, 8'hC6, 1, 1'b0);
    leave_mode();

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule